// File: doc/BRIEF.md
# Port Pin Ownership Multiplexer

This block decides, for every pin of an eight-pin port, who drives it: general-purpose I/O, or one of seven peripheral functions. The functions are a two-wire serial bus controller, three CAN-type bus controllers and three SPI controllers. Each function presents per-lane output values, per-lane output enables and an enable flag. The block returns per-lane receive values to each function, taken from the pins that function currently owns.

Ownership follows two inputs. The first is a routing register, which places the roaming CAN controller and moves the SPI controllers onto this port. The second is a fixed priority order, which settles pins that several enabled functions claim at the same time. Pins that no function owns fall back to the port's data and direction registers.

A small write port loads three registers: the data register, the direction register and the routing register. A read of the port returns, for each bit, the data register when that bit is an output, and the synchronized pin level when it is an input. The pin outputs, the output enables and the receive values are all registered.

Top module: `portmux_route`

## Requirements
- R1: After a synchronous reset, every output enable and pin output is 0, every receive lane is 1, and the read value is 0.
- R2: A pin owned by no function drives the data-register bit, and its output enable is the direction-register bit (1 = output). A register write appears on the pins two clock edges later.
- R3: Read data bit i is the data-register bit when direction bit i is 1. Otherwise it is the pin level delayed through a two-stage synchronizer.
- R4: When enabled, the two-wire bus function (index 0) always owns pins 1:0, with lane 0 on pin 0. It takes precedence over every other function and over general-purpose I/O.
- R5: Routing bits [3:2] place the roaming CAN controller (index 3): 00 puts it on pins 7:6, 01 on pins 5:4, and 10 or 11 leaves it unconnected, with those pins kept by general-purpose I/O.
- R6: On pins 5:4, CAN controller index 1 wins over index 2, and index 2 wins over index 3 only while index 1 is disabled.
- R7: Routing bit 4 places SPI index 4 on pins 5:2, bit 5 places SPI index 5 on pins 3:0, and bit 6 places SPI index 6 on pins 7:4. Otherwise each SPI controller is absent from the port. Among overlapping claims, the lower function index wins.
- R8: Lane l of a placed function maps to pin base+l. A receive lane carries the synchronized level of that pin only while the function owns it. All other lanes, including lanes beyond a function's width (two lanes for the bus and CAN functions, four for SPI), read 1.
- R9: A disabled function claims no pin and all its receive lanes read 1, whatever the routing register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 direction, 2 routing, 3 ignored |
| wr_data | input | 8 | Write value |
| rd_data | output | 8 | Port read value |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Output enable of each pad |
| fn_en | input | 7 | Enable flag of each function |
| fn_out | input | 7x4 | Per-lane output value of each function |
| fn_oe | input | 7x4 | Per-lane output enable of each function |
| fn_in | output | 7x4 | Per-lane receive value to each function |

## Verification
Two functions can meet in one cycle: a routing-register write can land on the same edge as a change in peripheral enables or pin levels. Ownership then moves at the same moment that receive data is being steered, so a wrong hand-over shows up as a stale or misrouted receive lane. A long phase of random writes, enables, lane values and pin levels provokes this collision repeatedly. A behavioural model in the bench predicts every output on every clock, and each prediction is compared at the falling edge.

// File: rtl/portmux_pkg.sv
package portmux_pkg;
  localparam int PINS    = 8;
  localparam int NFN     = 7;
  localparam int LANES   = 4;
  localparam int ROUTE_W = 8;
  localparam int PBW     = $clog2(PINS);
  localparam int FNW     = $clog2(NFN);
  localparam int LNW     = $clog2(LANES);

  typedef enum logic [FNW-1:0] {
    FN_TWI     = 3'd0,
    FN_CAN_HI  = 3'd1,
    FN_CAN_MID = 3'd2,
    FN_CAN_ROV = 3'd3,
    FN_SPI_A   = 3'd4,
    FN_SPI_B   = 3'd5,
    FN_SPI_C   = 3'd6
  } fn_e;

  typedef struct packed {
    logic           placed;
    logic [PBW-1:0] base;
    logic [PBW:0]   width;
  } slot_t;

  // placement of one function on the port for a given routing value
  function automatic slot_t slot_of(fn_e f, logic [ROUTE_W-1:0] route);
    slot_t s;
    s.placed = 1'b1;
    s.base   = '0;
    s.width  = (PBW+1)'(2);
    unique case (f)
      FN_TWI:                s.base = (PBW)'(0);
      FN_CAN_HI, FN_CAN_MID: s.base = (PBW)'(4);
      FN_CAN_ROV: begin
        case (route[3:2])
          2'b00:   s.base = (PBW)'(6);
          2'b01:   s.base = (PBW)'(4);
          default: s.placed = 1'b0;
        endcase
      end
      FN_SPI_A: begin s.placed = route[4]; s.base = (PBW)'(2); s.width = (PBW+1)'(4); end
      FN_SPI_B: begin s.placed = route[5]; s.base = (PBW)'(0); s.width = (PBW+1)'(4); end
      default:  begin s.placed = route[6]; s.base = (PBW)'(4); s.width = (PBW+1)'(4); end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/portmux_regs.sv
module portmux_regs
  import portmux_pkg::*;
#(
  parameter int W   = PINS,
  parameter int RW  = ROUTE_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q,
  output logic [RW-1:0] route_q,
  output logic [W-1:0]  pin_sync,
  output logic [W-1:0]  rd_data
);
  localparam int STAGES = 2;
  logic [STAGES-1:0][W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      route_q <= '0;
      sync_q  <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_in};
      if (wr_en) begin
        case (wr_addr)
          2'd0:    data_q  <= wr_data;
          2'd1:    dir_q   <= wr_data;
          2'd2:    route_q <= RW'(wr_data);
          default: ;
        endcase
      end
    end
  end

  assign pin_sync = sync_q[STAGES-1];
  assign rd_data  = (dir_q & data_q) | (~dir_q & pin_sync);

  // inputs read back the pad level seen two edges earlier
  assert_input_read_R3: assert property (@(posedge clk) disable iff (rst)
    (dir_q == '0 && !$past(rst) && !$past(rst, 2)) |-> rd_data == $past(pin_in, 2));
endmodule

// File: rtl/portmux_owner.sv
module portmux_owner
  import portmux_pkg::*;
#(
  parameter int W  = PINS,
  parameter int NF = NFN,
  parameter int RW = ROUTE_W
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RW-1:0]          route_q,
  input  logic [NF-1:0]          fn_en,
  output slot_t [NF-1:0]         slots,
  output logic  [NF-1:0]         fn_live,
  output logic  [W-1:0]          own_hit,
  output logic  [W-1:0][FNW-1:0] own_fn,
  output logic  [W-1:0][LNW-1:0] own_lane
);
  for (genvar f = 0; f < NF; f++) begin : g_slot
    assign slots[f]   = slot_of(fn_e'(f), route_q);
    assign fn_live[f] = fn_en[f] & slots[f].placed;
  end

  // descending scan: the lowest index claiming a pin is written last and wins
  always_comb begin
    own_hit  = '0;
    own_fn   = '0;
    own_lane = '0;
    for (int p = 0; p < W; p++) begin
      for (int f = NF-1; f >= 0; f--) begin
        if (fn_live[f] && p >= int'(slots[f].base) &&
            p < int'(slots[f].base) + int'(slots[f].width)) begin
          own_hit[p]  = 1'b1;
          own_fn[p]   = FNW'(f);
          own_lane[p] = LNW'(p - int'(slots[f].base));
        end
      end
    end
  end

  logic [W-1:0] rov_owned;
  always_comb
    for (int p = 0; p < W; p++)
      rov_owned[p] = own_hit[p] && (own_fn[p] == FN_CAN_ROV);

  assert_rov_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    route_q[3] |-> rov_owned == '0);

  assert_can_priority_R6: assert property (@(posedge clk) disable iff (rst)
    fn_en[FN_CAN_HI] |-> (own_fn[4] == FN_CAN_HI && own_fn[5] == FN_CAN_HI && own_hit[5:4] == 2'b11));
endmodule

// File: rtl/portmux_drive.sv
module portmux_drive
  import portmux_pkg::*;
#(
  parameter int W  = PINS,
  parameter int NF = NFN,
  parameter int NL = LANES
)(
  input  logic                   clk,
  input  logic                   rst,
  input  slot_t [NF-1:0]         slots,
  input  logic  [NF-1:0]         fn_live,
  input  logic  [W-1:0]          own_hit,
  input  logic  [W-1:0][FNW-1:0] own_fn,
  input  logic  [W-1:0][LNW-1:0] own_lane,
  input  logic  [W-1:0]          data_q,
  input  logic  [W-1:0]          dir_q,
  input  logic  [W-1:0]          pin_sync,
  input  logic  [NF-1:0][NL-1:0] fn_out,
  input  logic  [NF-1:0][NL-1:0] fn_oe,
  output logic  [W-1:0]          pin_out,
  output logic  [W-1:0]          pin_oe,
  output logic  [NF-1:0][NL-1:0] fn_in
);
  logic [W-1:0]          out_nxt, oe_nxt;
  logic [NF-1:0][NL-1:0] rx_nxt;
  int                    pidx;

  always_comb begin
    for (int p = 0; p < W; p++) begin
      if (own_hit[p]) begin
        out_nxt[p] = fn_out[own_fn[p]][own_lane[p]];
        oe_nxt[p]  = fn_oe[own_fn[p]][own_lane[p]];
      end else begin
        out_nxt[p] = data_q[p];
        oe_nxt[p]  = dir_q[p];
      end
    end
  end

  always_comb begin
    rx_nxt = '1;
    pidx   = 0;
    for (int f = 0; f < NF; f++) begin
      for (int l = 0; l < NL; l++) begin
        pidx = int'(slots[f].base) + l;
        if (fn_live[f] && l < int'(slots[f].width) && pidx < W) begin
          if (own_hit[pidx] && own_fn[pidx] == FNW'(f))
            rx_nxt[f][l] = pin_sync[pidx];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
      fn_in   <= '1;
    end else begin
      pin_out <= out_nxt;
      pin_oe  <= oe_nxt;
      fn_in   <= rx_nxt;
    end
  end

  assert_twi_owns_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fn_live[FN_TWI])) |->
      (pin_oe[1:0] == $past(fn_oe[FN_TWI][1:0]) && pin_out[1:0] == $past(fn_out[FN_TWI][1:0])));

  for (genvar f = 0; f < NF; f++) begin : g_idle
    assert_idle_rx_R9: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !$past(fn_live[f])) |-> fn_in[f] == '1);
  end
endmodule

// File: rtl/portmux_route.sv
module portmux_route
  import portmux_pkg::*;
#(
  parameter int W  = PINS,
  parameter int NF = NFN,
  parameter int NL = LANES
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [W-1:0]          wr_data,
  output logic [W-1:0]          rd_data,
  input  logic [W-1:0]          pin_in,
  output logic [W-1:0]          pin_out,
  output logic [W-1:0]          pin_oe,
  input  logic [NF-1:0]         fn_en,
  input  logic [NF-1:0][NL-1:0] fn_out,
  input  logic [NF-1:0][NL-1:0] fn_oe,
  output logic [NF-1:0][NL-1:0] fn_in
);
  logic [W-1:0]          data_q, dir_q, pin_sync;
  logic [ROUTE_W-1:0]    route_q;
  slot_t [NF-1:0]        slots;
  logic  [NF-1:0]        fn_live;
  logic  [W-1:0]         own_hit;
  logic  [W-1:0][FNW-1:0] own_fn;
  logic  [W-1:0][LNW-1:0] own_lane;

  portmux_regs #(.W(W), .RW(ROUTE_W)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .pin_in,
    .data_q, .dir_q, .route_q, .pin_sync, .rd_data
  );

  portmux_owner #(.W(W), .NF(NF), .RW(ROUTE_W)) u_owner (
    .clk, .rst, .route_q, .fn_en,
    .slots, .fn_live, .own_hit, .own_fn, .own_lane
  );

  portmux_drive #(.W(W), .NF(NF), .NL(NL)) u_drive (
    .clk, .rst, .slots, .fn_live, .own_hit, .own_fn, .own_lane,
    .data_q, .dir_q, .pin_sync, .fn_out, .fn_oe,
    .pin_out, .pin_oe, .fn_in
  );
endmodule

// File: tb/portmux_route_bench.sv
module portmux_route_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, pin_in = '0, rd_data, pin_out, pin_oe;
  logic [6:0] fn_en = '0;
  logic [6:0][3:0] fn_out = '0, fn_oe = '0, fn_in;

  portmux_route u_portmux_route (.*);

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  logic [7:0] m_data, m_dir, m_route, m_s1, m_s2, m_out, m_oe;
  logic [6:0][3:0] m_rx;

  function automatic void where(input int f, input logic [7:0] rt,
                                output bit ok, output int b, output int w);
    ok = 1; b = 0; w = 2;
    case (f)
      0: b = 0;
      1, 2: b = 4;
      3: if (rt[3:2] == 2'b00) b = 6; else if (rt[3:2] == 2'b01) b = 4; else ok = 0;
      4: begin ok = rt[4]; b = 2; w = 4; end
      5: begin ok = rt[5]; b = 0; w = 4; end
      default: begin ok = rt[6]; b = 4; w = 4; end
    endcase
  endfunction

  always @(posedge clk) begin : model
    int owner[8];
    int lane[8];
    bit ok;
    int b, w;
    logic [7:0] no, noe;
    logic [6:0][3:0] nrx;
    if (rst) begin
      m_data = 0; m_dir = 0; m_route = 0; m_s1 = 0; m_s2 = 0;
      m_out = 0; m_oe = 0; m_rx = '1;
    end else begin
      for (int p = 0; p < 8; p++) begin
        owner[p] = -1; lane[p] = 0;
        for (int f = 0; f < 7; f++) begin
          where(f, m_route, ok, b, w);
          if (owner[p] < 0 && fn_en[f] && ok && p >= b && p < b + w) begin
            owner[p] = f; lane[p] = p - b;
          end
        end
        no[p]  = owner[p] < 0 ? m_data[p] : fn_out[owner[p]][lane[p]];
        noe[p] = owner[p] < 0 ? m_dir[p]  : fn_oe[owner[p]][lane[p]];
      end
      nrx = '1;
      for (int f = 0; f < 7; f++) begin
        where(f, m_route, ok, b, w);
        for (int l = 0; l < 4; l++)
          if (fn_en[f] && ok && l < w && owner[b + l] == f) nrx[f][l] = m_s2[b + l];
      end
      m_out = no; m_oe = noe; m_rx = nrx;
      m_s2 = m_s1; m_s1 = pin_in;
      if (wr_en) case (wr_addr)
        2'd0: m_data = wr_data;
        2'd1: m_dir = wr_data;
        2'd2: m_route = wr_data;
        default: ;
      endcase
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(tag, "pin_out", 32'(pin_out), 32'(m_out));
    chk(tag, "pin_oe", 32'(pin_oe), 32'(m_oe));
    chk(tag, "fn_in", 32'(fn_in), 32'(m_rx));
    chk(tag, "rd_data", 32'(rd_data), 32'((m_dir & m_data) | (~m_dir & m_s2)));
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    idle(1);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    idle(3);
    cmp_on = 1'b1;
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1", "pin_oe", 32'(pin_oe), 0);
    chk("R1", "fn_in", 32'(fn_in), 32'h0FFF_FFFF);
    chk("R1", "rd_data", 32'(rd_data), 0);

    tag = "R2";
    wr(0, 8'hA5); wr(1, 8'h0F); idle(3);
    chk("R2", "pin_out", 32'(pin_out), 32'hA5);
    chk("R2", "pin_oe", 32'(pin_oe), 32'h0F);

    tag = "R3";
    pin_in = 8'h3C; idle(3);
    chk("R3", "mixed read", 32'(rd_data), 32'h35);
    wr(1, 8'hFF); idle(2);
    chk("R3", "output read", 32'(rd_data), 32'hA5);
    wr(1, 8'h00); pin_in = 8'hC3; idle(3);
    chk("R3", "input read", 32'(rd_data), 32'hC3);

    tag = "R4";
    fn_en = 7'b000_0001; fn_out[0] = 4'b0010; fn_oe[0] = 4'b0011;
    wr(2, 8'h20); fn_en = 7'b010_0001; fn_out[5] = 4'b0101; fn_oe[5] = 4'hF; idle(3);
    chk("R4", "pin_out[3:0]", 32'(pin_out[3:0]), 32'b0110);
    chk("R4", "pin_oe[3:0]", 32'(pin_oe[3:0]), 32'hF);
    fn_en = '0; fn_out = '0; fn_oe = '0;

    tag = "R5";
    wr(0, 8'h50); wr(1, 8'hF0);
    fn_en = 7'b000_1000; fn_out[3] = 4'b0010; fn_oe[3] = 4'b0010;
    wr(2, 8'h00); idle(3);
    chk("R5", "route00 out", 32'(pin_out[7:4]), 32'b1001);
    chk("R5", "route00 oe", 32'(pin_oe[7:4]), 32'b1011);
    wr(2, 8'h04); idle(3);
    chk("R5", "route01 out", 32'(pin_out[7:4]), 32'b0110);
    chk("R5", "route01 rx", 32'(fn_in[3]), 32'b1100);
    wr(2, 8'h08); idle(3);
    chk("R5", "route10 out", 32'(pin_out[7:4]), 32'b0101);
    chk("R5", "route10 rx", 32'(fn_in[3]), 32'hF);
    wr(2, 8'h0C); idle(3);
    chk("R5", "route11 oe", 32'(pin_oe[7:4]), 32'hF);

    tag = "R6";
    wr(2, 8'h04); pin_in = 8'h20;
    fn_en = 7'b000_1100; fn_out[2] = 4'b0001; fn_oe[2] = 4'b0011; idle(3);
    chk("R6", "mid over rov", 32'(pin_out[5:4]), 32'b01);
    fn_en = 7'b000_1110; fn_out[1] = 4'b0011; fn_oe[1] = 4'b0011; idle(4);
    chk("R6", "hi over mid", 32'(pin_out[5:4]), 32'b11);
    chk("R8", "hi rx", 32'(fn_in[1]), 32'b1110);
    chk("R8", "mid rx idle", 32'(fn_in[2]), 32'hF);
    fn_en = '0; fn_out = '0; fn_oe = '0;

    tag = "R7";
    wr(2, 8'h10); fn_en = 7'b001_0000; fn_out[4] = 4'b1001; fn_oe[4] = 4'hF; idle(3);
    chk("R7", "spi_a pins", 32'(pin_out[5:2]), 32'b1001);
    wr(2, 8'h40); fn_en = 7'b101_0000; fn_out[6] = 4'b0110; fn_oe[6] = 4'hF; idle(3);
    chk("R7", "spi_c pins", 32'(pin_out[7:4]), 32'b0110);
    chk("R7", "pins 3:2 gpio oe", 32'(pin_oe[3:2]), 0);
    chk("R8", "spi_a unplaced rx", 32'(fn_in[4]), 32'hF);

    tag = "R9";
    fn_en = '0; fn_out = '1; fn_oe = '1; wr(2, 8'h7C); idle(3);
    chk("R9", "disabled out", 32'(pin_out), 32'h50);
    chk("R9", "disabled oe", 32'(pin_oe), 32'hF0);
    chk("R9", "disabled rx", 32'(fn_in), 32'h0FFF_FFFF);

    tag = "R8";
    for (int i = 0; i < 800; i++) begin
      fn_en  = 7'($urandom);
      fn_out = 28'($urandom);
      fn_oe  = 28'($urandom);
      pin_in = 8'($urandom);
      wr_en  = ($urandom % 3) == 0;
      wr_addr = 2'($urandom);
      wr_data = 8'($urandom);
      idle(1);
    end
    wr_en = 1'b0;
    idle(2);
    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule